// File: doc/BRIEF.md
# Topology-Switchable PWM Gate Sequencer

This block turns a duty-cycle code into the two gate commands of a synchronous DC-DC power stage. The stage has a P-channel high-side transistor, whose gate command is active low, and an N-channel low-side transistor. A topology input selects step-down (buck) or step-up (boost) operation. In buck the high-side device is the main switch and the low-side device is the synchronous rectifier. In boost the roles are reversed. A free-running period counter of `2**CNT_W` clock cycles compares against the shaped duty value. A falling edge on an external sync input restarts the period early, so an external clock running 1.2 to 1.5 times faster than the natural period can take over the timing.

Between any gate turning off and the other turning on, the block holds both gates off for a programmable number of clock cycles. It also shapes the commanded duty at its extremes:
- Very small codes give no switching at all.
- In buck, codes above the 80% point snap to a full-period on state with the rectifier held off.
- In boost, the duty is clamped to 70%.
- In boost, the rectifier stays on for a minimum time once it has been turned on, even when a sync restart cuts the period short.

Duty codes arrive on a valid/ready input. `duty_ready` is low during reset and high at all times afterwards, so the block never applies back-pressure after reset. A code transfers on any clock edge where `duty_valid` and `duty_ready` are both high. The topology input is a plain level.

Top module: `pwm_topo_driver`

## Requirements
- R1: While `rst_n` is low, `hs_gate_n` is 1 (high side off), `ls_gate` is 0 (low side off) and `duty_ready` is 0. On the first edge after reset, `duty_ready` becomes 1 and stays 1.
- R2: Buck (`boost_mode`=0) with a shaped duty L where 0 < L < 2**CNT_W: the high side is on for L−DEAD cycles and the low side is on for 2**CNT_W−L−DEAD cycles per period. The rectifier keeps switching whatever the load.
- R3: Boost (`boost_mode`=1): the low side is the main switch (on L−DEAD cycles) and the high side is the rectifier (on 2**CNT_W−L−DEAD cycles).
- R4: The two gates are never on together. A gate turns on only after both gates have been off for at least DEAD consecutive cycles.
- R5: In buck, a code above SNAP = floor(2**CNT_W·80/100) (51 by default) makes the high side stay on for the whole period with the low side off. The code SNAP itself switches normally.
- R6: In boost, a code above BMAX = floor(2**CNT_W·70/100) (44 by default) is treated as BMAX.
- R7: A code below MIN_CODE (4 by default) gives 0% duty, with both gates held off. MIN_CODE itself switches.
- R8: The period counter restarts at zero on the third rising edge, counting the edge that first samples `sync_in` low after it was high.
- R9: In boost, every high-side (rectifier) on-interval lasts at least RECT_MIN cycles, including when a sync restart requests the main switch early.
- R10: A transferred code, and the current `boost_mode` level, take effect only at the next period start (counter wrap or sync restart). A code transferred on the start edge itself waits for the following start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boost_mode | input | 1 | 0 = buck, 1 = boost; sampled at each period start |
| duty_valid | input | 1 | Duty code offered |
| duty_ready | output | 1 | Code accepted when high together with `duty_valid` |
| duty_code | input | CNT_W | Commanded on-time in counter steps |
| sync_in | input | 1 | External sync; a falling edge restarts the period |
| hs_gate_n | output | 1 | High-side P-channel gate command, 0 = on |
| ls_gate | output | 1 | Low-side N-channel gate command, 1 = on |

## Verification
The rectifier minimum-time property assumes that RECT_MIN is shorter than the boost off-time, and that sync restarts are spaced well apart from each other. The sync edge detector assumes that `sync_in` holds each level for at least two clock cycles. The stimulus drives sync with 25-cycle low and high phases, which is a restart every 50 cycles against a 64-cycle natural period (ratio 1.28). This places restarts just after the rectifier has turned on, so the hold path is exercised. Duty codes and topology changes are applied at arbitrary points in the period, and the outputs are left to settle for two periods before on-time totals are measured.

// File: rtl/pwm_topo_pkg.sv
package pwm_topo_pkg;
  typedef enum logic {TOPO_BUCK = 1'b0, TOPO_BOOST = 1'b1} topo_e;
endpackage

// File: rtl/pwm_period_timer.sv
module pwm_period_timer #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_in,
  output logic [CNT_W-1:0] cnt,
  output logic             start
);
  localparam logic [CNT_W-1:0] CNT_LAST = '1;

  logic [2:0] sync_sr;
  logic       restart;

  // two-stage synchronizer followed by an edge register
  always_ff @(posedge clk) begin
    if (!rst_n) sync_sr <= 3'b111;
    else        sync_sr <= {sync_sr[1:0], sync_in};
  end

  assign restart = sync_sr[2] & ~sync_sr[1];
  assign start   = (cnt == CNT_LAST) | restart;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (start) cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end

  a_r8_sync_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0));
endmodule

// File: rtl/pwm_duty_shaper.sv
module pwm_duty_shaper
  import pwm_topo_pkg::*;
#(
  parameter int CNT_W     = 6,
  parameter int BOOST_PCT = 70,
  parameter int SNAP_PCT  = 80,
  parameter int MIN_CODE  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] cnt,
  input  logic             boost_mode,
  input  logic             duty_valid,
  input  logic [CNT_W-1:0] duty_code,
  output logic             duty_ready,
  output topo_e            topo,
  output logic             main_req,
  output logic             rect_req
);
  localparam int PERIOD    = 1 << CNT_W;
  localparam int LIM_W     = CNT_W + 1;
  localparam int BOOST_MAX = (PERIOD * BOOST_PCT) / 100;
  localparam int SNAP_CODE = (PERIOD * SNAP_PCT) / 100;
  localparam logic [LIM_W-1:0] FULL = LIM_W'(PERIOD);

  logic [CNT_W-1:0] pend_code;
  logic [LIM_W-1:0] duty_lim;
  logic             full_on;

  function automatic logic [LIM_W-1:0] shape(input logic [CNT_W-1:0] code, input topo_e t);
    int d;
    int r;
    d = int'(code);
    if (d < MIN_CODE)         r = 0;
    else if (t == TOPO_BOOST) r = (d > BOOST_MAX) ? BOOST_MAX : d;
    else                      r = (d > SNAP_CODE) ? PERIOD : d;
    return LIM_W'(r);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      duty_ready <= 1'b0;
      pend_code  <= '0;
    end else begin
      duty_ready <= 1'b1;
      if (duty_valid && duty_ready) pend_code <= duty_code;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      topo     <= TOPO_BUCK;
      duty_lim <= '0;
    end else if (start) begin
      topo     <= topo_e'(boost_mode);
      duty_lim <= shape(pend_code, topo_e'(boost_mode));
    end
  end

  assign full_on  = (duty_lim == FULL);
  assign main_req = ({1'b0, cnt} < duty_lim);
  assign rect_req = (duty_lim != '0) & ~full_on & ~main_req;

  a_r6_boost_clamp: assert property (@(posedge clk) disable iff (!rst_n)
    (topo == TOPO_BOOST) |-> (duty_lim <= LIM_W'(BOOST_MAX)));
  a_r5_full_only_buck: assert property (@(posedge clk) disable iff (!rst_n)
    full_on |-> (topo == TOPO_BUCK));
  a_r7_no_tiny_duty: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_lim == '0) || (duty_lim >= LIM_W'(MIN_CODE)));
  a_r10_hold_mid_period: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(duty_lim));
endmodule

// File: rtl/pwm_gate_sequencer.sv
module pwm_gate_sequencer
  import pwm_topo_pkg::*;
#(
  parameter int DEAD     = 3,
  parameter int RECT_MIN = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  topo_e topo,
  input  logic  main_req,
  input  logic  rect_req,
  output logic  hs_on,
  output logic  ls_on
);
  localparam int GAP_W  = $clog2(DEAD + 1);
  localparam int HOLD_W = $clog2(RECT_MIN + 1);
  localparam logic [GAP_W-1:0]  GAP_MAX  = GAP_W'(DEAD);
  localparam logic [HOLD_W-1:0] HOLD_TOP = HOLD_W'(RECT_MIN - 1);
  localparam logic [HOLD_W-1:0] RUN_MAX  = HOLD_W'(RECT_MIN);

  logic [GAP_W-1:0]  gap;
  logic [HOLD_W-1:0] hold;
  logic              hs_req, ls_req, hs_want;
  logic              hs_nxt, ls_nxt, gap_ok, is_boost;

  assign is_boost = (topo == TOPO_BOOST);
  assign hs_req   = is_boost ? rect_req : main_req;
  assign ls_req   = is_boost ? main_req : rect_req;
  assign hs_want  = hs_req | (is_boost & (hold != '0));
  assign gap_ok   = (gap >= GAP_MAX);

  // turn-off is immediate; turn-on waits for the dead gap, high side has priority
  always_comb begin
    hs_nxt = hs_on ? hs_want : (hs_want & ~ls_on & gap_ok);
    ls_nxt = ls_on ? ls_req  : (ls_req & ~hs_want & ~hs_on & gap_ok);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_on <= 1'b0;
      ls_on <= 1'b0;
      gap   <= '0;
      hold  <= '0;
    end else begin
      hs_on <= hs_nxt;
      ls_on <= ls_nxt;
      if (hs_nxt | ls_nxt)  gap <= '0;
      else if (!gap_ok)     gap <= gap + 1'b1;
      if (is_boost && !hs_on && hs_nxt) hold <= HOLD_TOP;
      else if (hold != '0)              hold <= hold - 1'b1;
    end
  end

  // observation state for the rectifier minimum-time check
  logic [HOLD_W-1:0] run_len;
  logic              run_boost;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_len   <= '0;
      run_boost <= 1'b0;
    end else if (hs_nxt && !hs_on) begin
      run_len   <= HOLD_W'(1);
      run_boost <= is_boost;
    end else begin
      if (hs_nxt && run_len != RUN_MAX) run_len <= run_len + 1'b1;
      run_boost <= run_boost & is_boost;
    end
  end

  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_on && ls_on));
  a_r4_gap_before_hs: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_on) |-> ($past(gap) >= GAP_MAX) && $past(!ls_on));
  a_r4_gap_before_ls: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_on) |-> ($past(gap) >= GAP_MAX) && $past(!hs_on));
  a_r9_rect_min: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hs_on) && $past(run_boost)) |-> ($past(run_len) >= RUN_MAX));
endmodule

// File: rtl/pwm_topo_driver.sv
module pwm_topo_driver
  import pwm_topo_pkg::*;
#(
  parameter int CNT_W     = 6,
  parameter int DEAD      = 3,
  parameter int RECT_MIN  = 4,
  parameter int BOOST_PCT = 70,
  parameter int SNAP_PCT  = 80,
  parameter int MIN_CODE  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boost_mode,
  input  logic             duty_valid,
  output logic             duty_ready,
  input  logic [CNT_W-1:0] duty_code,
  input  logic             sync_in,
  output logic             hs_gate_n,
  output logic             ls_gate
);
  logic [CNT_W-1:0] cnt;
  logic             start, main_req, rect_req, hs_on, ls_on;
  topo_e            topo;

  pwm_period_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .sync_in(sync_in), .cnt(cnt), .start(start)
  );

  pwm_duty_shaper #(
    .CNT_W(CNT_W), .BOOST_PCT(BOOST_PCT), .SNAP_PCT(SNAP_PCT), .MIN_CODE(MIN_CODE)
  ) u_shaper (
    .clk(clk), .rst_n(rst_n), .start(start), .cnt(cnt), .boost_mode(boost_mode),
    .duty_valid(duty_valid), .duty_code(duty_code), .duty_ready(duty_ready),
    .topo(topo), .main_req(main_req), .rect_req(rect_req)
  );

  pwm_gate_sequencer #(.DEAD(DEAD), .RECT_MIN(RECT_MIN)) u_seq (
    .clk(clk), .rst_n(rst_n), .topo(topo), .main_req(main_req), .rect_req(rect_req),
    .hs_on(hs_on), .ls_on(ls_on)
  );

  assign hs_gate_n = ~hs_on;
  assign ls_gate   = ls_on;
endmodule

// File: tb/sim_pwm_topo_driver.sv
module sim_pwm_topo_driver;
  localparam int CNT_W = 6;
  localparam int P     = 1 << CNT_W;
  localparam int DEAD  = 3;
  localparam int RMIN  = 4;
  localparam int BMAX  = 44;
  localparam int SNAP  = 51;
  localparam int MINC  = 4;

  logic clk = 1'b0, rst_n = 1'b0, boost_mode = 1'b0, duty_valid = 1'b0, sync_in = 1'b1;
  logic [CNT_W-1:0] duty_code = '0;
  logic duty_ready, hs_gate_n, ls_gate;

  int errors = 0, checks = 0;
  string cur_req = "R1";
  bit mon_on = 0, done = 0;

  always #5 clk = ~clk;

  pwm_topo_driver u0 (
    .clk(clk), .rst_n(rst_n), .boost_mode(boost_mode), .duty_valid(duty_valid),
    .duty_ready(duty_ready), .duty_code(duty_code), .sync_in(sync_in),
    .hs_gate_n(hs_gate_n), .ls_gate(ls_gate)
  );

  task automatic chk(bit ok, string rq, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", rq, act, exp, $time);
    end
  endtask

  // behavioural reference, updated every rising edge
  int m_s1, m_s2, m_s3, m_cnt, m_pend, m_rdy, m_lim, m_boost, m_hs, m_ls, m_gap, m_hold;

  function automatic int shape_ref(int d, int bst);
    if (d < MINC) return 0;
    if (bst != 0) return (d > BMAX) ? BMAX : d;
    return (d > SNAP) ? P : d;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 = 1; m_s2 = 1; m_s3 = 1; m_cnt = 0; m_pend = 0; m_rdy = 0;
      m_lim = 0; m_boost = 0; m_hs = 0; m_ls = 0; m_gap = 0; m_hold = 0;
    end else begin
      bit restart, wrap, on_main, on_rect, want_hs, want_ls, keep, nh, nl;
      restart = (m_s3 == 1) && (m_s2 == 0);
      wrap    = (m_cnt == P - 1);
      on_main = m_cnt < m_lim;
      on_rect = (m_lim != 0) && (m_lim != P) && !on_main;
      want_hs = m_boost ? on_rect : on_main;
      want_ls = m_boost ? on_main : on_rect;
      keep    = (m_boost != 0) && (m_hold > 0);
      want_hs = want_hs || keep;
      nh = m_hs ? want_hs : (want_hs && !m_ls && m_gap >= DEAD);
      nl = m_ls ? want_ls : (want_ls && !want_hs && !m_hs && m_gap >= DEAD);
      if (m_boost != 0 && !m_hs && nh) m_hold = RMIN - 1;
      else if (m_hold > 0)             m_hold = m_hold - 1;
      m_gap = (nh || nl) ? 0 : ((m_gap < DEAD) ? m_gap + 1 : DEAD);
      m_hs = nh; m_ls = nl;
      if (restart || wrap) begin
        m_cnt = 0;
        m_boost = boost_mode;
        m_lim = shape_ref(m_pend, boost_mode);
      end else m_cnt = m_cnt + 1;
      if (duty_valid && m_rdy != 0) m_pend = duty_code;
      m_rdy = 1;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = sync_in;
    end
  end

  // per-cycle comparison and generic R4/R9 observation
  int offrun = 0, hs_run = 0;
  bit prev_hs = 0, prev_ls = 0, run_bst = 0;
  always @(negedge clk) begin
    if (mon_on) begin
      bit hs, ls;
      hs = !hs_gate_n; ls = ls_gate;
      chk(hs_gate_n == (m_hs ? 1'b0 : 1'b1), cur_req, hs_gate_n, m_hs ? 0 : 1);
      chk(ls_gate == m_ls[0], cur_req, ls_gate, m_ls);
      chk(duty_ready == 1'b1, "R1", duty_ready, 1);
      chk(!(hs && ls), "R4 overlap", 1, 0);
      if ((hs && !prev_hs) || (ls && !prev_ls)) chk(offrun >= DEAD, "R4 gap", offrun, DEAD);
      if (hs && !prev_hs) begin hs_run = 1; run_bst = (m_boost != 0); end
      else if (hs) begin hs_run++; run_bst = run_bst && (m_boost != 0); end
      else if (prev_hs && run_bst) chk(hs_run >= RMIN, "R9", hs_run, RMIN);
      offrun = (!hs && !ls) ? offrun + 1 : 0;
      prev_hs = hs; prev_ls = ls;
    end
  end

  task automatic apply(int code, bit bst);
    @(negedge clk);
    duty_valid = 1'b1; duty_code = CNT_W'(code); boost_mode = bst;
    @(negedge clk);
    duty_valid = 1'b0;
    cur_req = "R10";
    repeat (2 * P + 8) @(negedge clk);
  endtask

  task automatic measure(string rq, int exp_hs, int exp_ls);
    int nh = 0, nl = 0;
    cur_req = rq;
    for (int i = 0; i < P; i++) begin
      @(negedge clk); #1;
      if (!hs_gate_n) nh++;
      if (ls_gate) nl++;
    end
    chk(nh == exp_hs, {rq, " high-side on-count"}, nh, exp_hs);
    chk(nl == exp_ls, {rq, " low-side on-count"}, nl, exp_ls);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(hs_gate_n == 1'b1, "R1 reset hs", hs_gate_n, 1);
    chk(ls_gate == 1'b0, "R1 reset ls", ls_gate, 0);
    chk(duty_ready == 1'b0, "R1 reset ready", duty_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1;
    apply(32, 0); measure("R2", 32 - DEAD, P - 32 - DEAD);
    apply(60, 0); measure("R5", P, 0);
    apply(SNAP, 0); measure("R5", SNAP - DEAD, P - SNAP - DEAD);
    apply(3, 0);  measure("R7", 0, 0);
    apply(MINC, 0); measure("R7", MINC - DEAD, P - MINC - DEAD);
    apply(20, 1); measure("R3", P - 20 - DEAD, 20 - DEAD);
    apply(60, 1); measure("R6", P - BMAX - DEAD, BMAX - DEAD);
    apply(BMAX, 1);
    cur_req = "R8";
    for (int k = 0; k < 8; k++) begin
      sync_in = 1'b0; repeat (25) @(negedge clk);
      sync_in = 1'b1; repeat (25) @(negedge clk);
    end
    cur_req = "R9";
    repeat (2 * P) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule